// File: doc/BRIEF.md
# Device Register Window Decoder

This block is the read-mostly register window of an accelerator or memory-expansion device. A host register bus presents one request per cycle (valid, write flag, byte address, byte count, write data). The window decodes the address into a capability area, a device event-status register and a memory-device status register. For every legal read it returns the requested bytes, little-endian and zero-extended, on the cycle after the request. Host writes are accepted and dropped everywhere. A request with a bad size or alignment answers with zero data and a one-cycle error flag.

The event-status register holds one bit per event-log type. Internal logic sets or clears those bits one index at a time through dedicated set and clear inputs. The capability area holds a 64-bit header and three 16-byte capability entries built from 32-bit registers. Each entry gives the identifier, version, offset and length of one register region.

Response sequencing is a small state machine. Its states are `ST_IDLE` (no response), `ST_RDATA` (read data valid), `ST_RERR` (read rejected) and `ST_WERR` (write rejected). Each cycle the next state follows from the current request alone:
- IDLE-ON-NONE: no request leads to `ST_IDLE`.
- IDLE-ON-WRITE: a legal write leads to `ST_IDLE`.
- GOTO-RDATA: a legal read leads to `ST_RDATA`.
- GOTO-RERR: an illegal read leads to `ST_RERR`.
- GOTO-WERR: an illegal write leads to `ST_WERR`.

Every state can take every transition, so requests can follow each other back to back.

Top module: `devreg_window`

## Requirements
- R1: After reset every event-status bit is 0, and `rd_valid` and `acc_err` are 0.
- R2: An 8-byte read at address 0x000 returns the capability header 0x0000_0003_0001_0000: identifier 0 in bits [15:0], version 1 in bits [23:16], entry count 3 in bits [47:32].
- R3: Capability entry k (k = 0..2) starts at 0x010 + 16*k and is read as four 32-bit registers:
  - +0 holds the identifier in [15:0] and the version in [23:16]. The identifier/version pairs are 0x0001/2, 0x0002/1 and 0x4000/1.
  - +4 holds the region offset: 0x100, 0x180 and 0x200.
  - +8 holds the region length: 0x80, 0x80 and 0x8.
  - +12 reads 0.
- R4: Reads of the memory-device status register at 0x200 return 0x14: mailbox-ready is bit 4 = 1 and media status is bits [3:2] = 01.
- R5: The event-status register at 0x100 holds bit N for log type N (N < 5); all higher bits read 0. A set request for index N sets bit N and a clear request clears it. When set and clear name the same index in one cycle, the set wins. An index of 5 or more changes nothing.
- R6: A read of the event-status register returns the value held before any set or clear presented in the same cycle.
- R7: A 1-, 2- or 4-byte read at address A returns bytes A.. of the aligned 8-byte image, least significant byte first, zero-extended to 64 bits.
- R8: `rd_valid` is high for exactly the one cycle after each read request, including back-to-back requests. With no request it stays low.
- R9: A request whose byte count (`req_size`, 4-bit) is not 1, 2, 4 or 8, or whose address is not a multiple of the byte count, raises `acc_err` for one cycle with `rd_data` = 0. For a read, `rd_valid` is raised in the same cycle.
- R10: An 8-byte access anywhere in the 32-bit capability-entry area 0x010..0x03F is rejected as in R9.
- R11: Legal host writes change no register, produce no `rd_valid` and no `acc_err`.
- R12: Legal reads of unmapped addresses return 0 with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present this cycle |
| req_write | input | 1 | Request is a write (1) or a read (0) |
| req_addr | input | ADDR_W | Byte address within the window |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data, discarded |
| evt_set_valid | input | 1 | Set one event-status bit |
| evt_set_idx | input | EVT_IDX_W | Log type to set |
| evt_clr_valid | input | 1 | Clear one event-status bit |
| evt_clr_idx | input | EVT_IDX_W | Log type to clear |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 64 | Little-endian read data |
| acc_err | output | 1 | Request rejected |

## Verification
The assertions assume a synchronous reset held over at least one clock edge. They assume that `req_write`, `req_addr` and `req_size` are meaningful whenever `req_valid` is high, and that the event inputs are idle during reset. The bench drives every input on the falling edge and forces valid strobes low outside the cycles it means to use. Illegal sizes and misaligned addresses are applied deliberately, so the error properties are exercised rather than assumed away.

// File: rtl/devreg_pkg.sv
package devreg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RDATA = 2'd1,
        ST_RERR  = 2'd2,
        ST_WERR  = 2'd3
    } win_state_e;

    localparam int unsigned NUM_CAPS   = 3;
    localparam int unsigned ENT_BYTES  = 16;
    localparam int unsigned ENT_BASE   = 'h10;
    localparam logic [63:0] CAP_HEADER = 64'h0000_0003_0001_0000;
    localparam logic [63:0] MDEV_STAT  = 64'h0000_0000_0000_0014;

    localparam logic [15:0] CAP_IDS [NUM_CAPS] = '{16'h0001, 16'h0002, 16'h4000};
    localparam logic [7:0]  CAP_VERS[NUM_CAPS] = '{8'd2, 8'd1, 8'd1};

    function automatic logic size_legal(input logic [3:0] sz);
        return (sz == 4'd1) || (sz == 4'd2) || (sz == 4'd4) || (sz == 4'd8);
    endfunction

    function automatic logic [63:0] size_mask(input logic [3:0] sz);
        logic [63:0] m;
        unique case (sz)
            4'd1:    m = 64'h0000_0000_0000_00FF;
            4'd2:    m = 64'h0000_0000_0000_FFFF;
            4'd4:    m = 64'h0000_0000_FFFF_FFFF;
            default: m = 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/devreg_decode.sv
module devreg_decode
    import devreg_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        size,
    output logic [ADDR_W-4:0] word_idx,
    output logic [2:0]        byte_off,
    output logic              acc_bad
);
    localparam int unsigned ENT_END = ENT_BASE + NUM_CAPS * ENT_BYTES;

    logic [3:0] low_mask;
    logic       misaligned;
    logic       in_entries;
    logic       wide_in_32;

    always_comb begin
        word_idx   = addr[ADDR_W-1:3];
        byte_off   = addr[2:0];
        low_mask   = size - 4'd1;
        misaligned = |(addr[2:0] & low_mask[2:0]);
        in_entries = (addr >= ADDR_W'(ENT_BASE)) && (addr < ADDR_W'(ENT_END));
        wide_in_32 = (size == 4'd8) && in_entries;
        acc_bad    = !size_legal(size) || misaligned || wide_in_32;
    end
endmodule

// File: rtl/devreg_evt.sv
module devreg_evt #(
    parameter int unsigned NUM_LOGS  = 5,
    parameter int unsigned EVT_IDX_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_valid,
    input  logic [EVT_IDX_W-1:0] set_idx,
    input  logic                 clr_valid,
    input  logic [EVT_IDX_W-1:0] clr_idx,
    output logic [NUM_LOGS-1:0]  bits_q
);
    for (genvar i = 0; i < NUM_LOGS; i++) begin : g_bit
        localparam logic [EVT_IDX_W-1:0] MY_IDX = EVT_IDX_W'(i);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bits_q[i] <= 1'b0;
            end else if (set_valid && set_idx == MY_IDX) begin
                bits_q[i] <= 1'b1;
            end else if (clr_valid && clr_idx == MY_IDX) begin
                bits_q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/devreg_image.sv
module devreg_image
    import devreg_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned NUM_LOGS = 5,
    parameter int unsigned DEV_OFF  = 'h100,
    parameter int unsigned DEV_LEN  = 'h80,
    parameter int unsigned MBX_OFF  = 'h180,
    parameter int unsigned MBX_LEN  = 'h80,
    parameter int unsigned MDEV_OFF = 'h200,
    parameter int unsigned MDEV_LEN = 'h8
) (
    input  logic [ADDR_W-4:0]   word_idx,
    input  logic [NUM_LOGS-1:0] evt_bits,
    output logic [63:0]         lane
);
    localparam int unsigned WORD_W    = ADDR_W - 3;
    localparam int unsigned ENT_WORD0 = ENT_BASE / 8;
    localparam int unsigned ENT_WORDS = NUM_CAPS * ENT_BYTES / 8;
    localparam logic [31:0] REG_OFF [NUM_CAPS] = '{32'(DEV_OFF), 32'(MBX_OFF), 32'(MDEV_OFF)};
    localparam logic [31:0] REG_LEN [NUM_CAPS] = '{32'(DEV_LEN), 32'(MBX_LEN), 32'(MDEV_LEN)};

    logic [63:0] ent_word [ENT_WORDS];

    for (genvar k = 0; k < NUM_CAPS; k++) begin : g_ent
        assign ent_word[2*k]   = {REG_OFF[k], 8'h00, CAP_VERS[k], CAP_IDS[k]};
        assign ent_word[2*k+1] = {32'h0, REG_LEN[k]};
    end

    always_comb begin
        lane = '0;
        if (word_idx == '0) begin
            lane = CAP_HEADER;
        end
        for (int w = 0; w < ENT_WORDS; w++) begin
            if (word_idx == WORD_W'(ENT_WORD0 + w)) begin
                lane = ent_word[w];
            end
        end
        if (word_idx == WORD_W'(DEV_OFF / 8)) begin
            lane = 64'(evt_bits);
        end
        if (word_idx == WORD_W'(MDEV_OFF / 8)) begin
            lane = MDEV_STAT;
        end
    end
endmodule

// File: rtl/devreg_window.sv
module devreg_window
    import devreg_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_LOGS  = 5,
    parameter int unsigned EVT_IDX_W = 3,
    parameter int unsigned DEV_OFF   = 'h100,
    parameter int unsigned MBX_OFF   = 'h180,
    parameter int unsigned MDEV_OFF  = 'h200
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [3:0]           req_size,
    input  logic [63:0]          req_wdata,
    input  logic                 evt_set_valid,
    input  logic [EVT_IDX_W-1:0] evt_set_idx,
    input  logic                 evt_clr_valid,
    input  logic [EVT_IDX_W-1:0] evt_clr_idx,
    output logic                 rd_valid,
    output logic [63:0]          rd_data,
    output logic                 acc_err
);
    localparam int unsigned DEV_LEN  = MBX_OFF - DEV_OFF;
    localparam int unsigned MBX_LEN  = MDEV_OFF - MBX_OFF;
    localparam int unsigned MDEV_LEN = 8;

    win_state_e          state_q, state_d;
    logic [ADDR_W-4:0]   word_idx;
    logic [2:0]          byte_off;
    logic                acc_bad;
    logic [NUM_LOGS-1:0] evt_bits;
    logic [63:0]         lane;
    logic [63:0]         shaped;
    logic [63:0]         data_q;
    logic                wdata_unused;

    assign wdata_unused = ^req_wdata;

    devreg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr     (req_addr),
        .size     (req_size),
        .word_idx (word_idx),
        .byte_off (byte_off),
        .acc_bad  (acc_bad)
    );

    devreg_evt #(.NUM_LOGS(NUM_LOGS), .EVT_IDX_W(EVT_IDX_W)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_valid (evt_set_valid),
        .set_idx   (evt_set_idx),
        .clr_valid (evt_clr_valid),
        .clr_idx   (evt_clr_idx),
        .bits_q    (evt_bits)
    );

    devreg_image #(
        .ADDR_W  (ADDR_W),
        .NUM_LOGS(NUM_LOGS),
        .DEV_OFF (DEV_OFF),
        .DEV_LEN (DEV_LEN),
        .MBX_OFF (MBX_OFF),
        .MBX_LEN (MBX_LEN),
        .MDEV_OFF(MDEV_OFF),
        .MDEV_LEN(MDEV_LEN)
    ) u_image (
        .word_idx (word_idx),
        .evt_bits (evt_bits),
        .lane     (lane)
    );

    // Next state is decided by the current request only.
    always_comb begin
        state_d = ST_IDLE;
        unique case ({req_valid, acc_bad, req_write})
            3'b100:  state_d = ST_RDATA;
            3'b101:  state_d = ST_IDLE;
            3'b110:  state_d = ST_RERR;
            3'b111:  state_d = ST_WERR;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign shaped = (lane >> {byte_off, 3'b000}) & size_mask(req_size);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (state_d == ST_RDATA) begin
            data_q <= shaped;
        end else begin
            data_q <= '0;
        end
    end

    always_comb begin
        rd_valid = 1'b0;
        acc_err  = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin rd_valid = 1'b0; acc_err = 1'b0; end
            ST_RDATA: begin rd_valid = 1'b1; acc_err = 1'b0; end
            ST_RERR:  begin rd_valid = 1'b1; acc_err = 1'b1; end
            ST_WERR:  begin rd_valid = 1'b0; acc_err = 1'b1; end
            default:  begin rd_valid = 1'b0; acc_err = 1'b0; end
        endcase
        rd_data = data_q;
    end
endmodule

// File: rtl/devreg_window_chk.sv
module devreg_window_chk
    import devreg_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_LOGS  = 5,
    parameter int unsigned EVT_IDX_W = 3,
    parameter int unsigned MDEV_OFF  = 'h200
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [ADDR_W-1:0]    req_addr,
    input logic [3:0]           req_size,
    input logic                 evt_set_valid,
    input logic [EVT_IDX_W-1:0] evt_set_idx,
    input logic                 evt_clr_valid,
    input logic [EVT_IDX_W-1:0] evt_clr_idx,
    input logic [NUM_LOGS-1:0]  evt_bits,
    input logic                 rd_valid,
    input logic [63:0]          rd_data,
    input logic                 acc_err
);
    logic size_ok_now;
    assign size_ok_now = (req_size == 4'd1) || (req_size == 4'd2) || (req_size == 4'd4) || (req_size == 4'd8);

    AST_HDR_READ:     assert property (@(posedge clk) disable iff (!rst_n) req_valid && !req_write && req_addr == '0 && req_size == 4'd8 |=> rd_valid && rd_data == CAP_HEADER); // R2
    AST_MDEV_READ:    assert property (@(posedge clk) disable iff (!rst_n) req_valid && !req_write && req_addr == ADDR_W'(MDEV_OFF) && req_size == 4'd8 |=> rd_valid && rd_data == MDEV_STAT); // R4
    AST_EVT_SET:      assert property (@(posedge clk) disable iff (!rst_n) evt_set_valid && evt_set_idx < EVT_IDX_W'(NUM_LOGS) |=> evt_bits[$past(evt_set_idx)]); // R5
    AST_EVT_CLR:      assert property (@(posedge clk) disable iff (!rst_n) evt_clr_valid && evt_clr_idx < EVT_IDX_W'(NUM_LOGS) && !(evt_set_valid && evt_set_idx == evt_clr_idx) |=> !evt_bits[$past(evt_clr_idx)]); // R5
    AST_IDLE_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rd_valid && !acc_err); // R8
    AST_BAD_SIZE:     assert property (@(posedge clk) disable iff (!rst_n) req_valid && !size_ok_now |=> acc_err); // R9
    AST_ERR_ZERO:     assert property (@(posedge clk) disable iff (!rst_n) acc_err |-> rd_data == '0); // R9
    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) req_valid && req_write |=> !rd_valid); // R11
endmodule

bind devreg_window devreg_window_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_LOGS (NUM_LOGS),
    .EVT_IDX_W(EVT_IDX_W),
    .MDEV_OFF (MDEV_OFF)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_size     (req_size),
    .evt_set_valid(evt_set_valid),
    .evt_set_idx  (evt_set_idx),
    .evt_clr_valid(evt_clr_valid),
    .evt_clr_idx  (evt_clr_idx),
    .evt_bits     (evt_bits),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .acc_err      (acc_err)
);

// File: tb/tb_devreg_window.sv
`timescale 1ns/1ps
module tb_devreg_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [3:0]  req_size = 4'd8;
    logic [63:0] req_wdata = '0;
    logic        evt_set_valid = 1'b0;
    logic [2:0]  evt_set_idx = '0;
    logic        evt_clr_valid = 1'b0;
    logic [2:0]  evt_clr_idx = '0;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic        acc_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int model_evt = 0;   // reference event bits

    always #4 clk = ~clk;

    devreg_window dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .evt_set_valid(evt_set_valid), .evt_set_idx(evt_set_idx),
        .evt_clr_valid(evt_clr_valid), .evt_clr_idx(evt_clr_idx),
        .rd_valid(rd_valid), .rd_data(rd_data), .acc_err(acc_err)
    );

    function automatic logic [63:0] ref_lane(int unsigned word);
        case (word)
            0:  return 64'h0000_0003_0001_0000;
            2:  return 64'h0000_0100_0002_0001;
            3:  return 64'h0000_0000_0000_0080;
            4:  return 64'h0000_0180_0001_0002;
            5:  return 64'h0000_0000_0000_0080;
            6:  return 64'h0000_0200_0001_4000;
            7:  return 64'h0000_0000_0000_0008;
            32: return 64'(model_evt);
            64: return 64'h14;
            default: return 64'h0;
        endcase
    endfunction

    task automatic check(string tag, logic av, logic ae, logic [63:0] ad,
                         logic ev, logic ee, logic [63:0] ed);
        checks++;
        if (av !== ev || ae !== ee || ad !== ed) begin
            errors++;
            $display("FAIL %s: actual v=%0b e=%0b d=%h expected v=%0b e=%0b d=%h",
                     tag, av, ae, ad, ev, ee, ed);
        end
    endtask

    // One clock of stimulus against the reference model, compared after the edge.
    task automatic step(string tag, bit v, bit w, int unsigned a, int unsigned s,
                        bit sv, int unsigned si, bit cv, int unsigned ci);
        logic        ev = 1'b0, ee = 1'b0;
        logic [63:0] ed = '0;
        bit          legal;
        req_valid = v; req_write = w; req_addr = 12'(a); req_size = 4'(s);
        req_wdata = 64'hDEAD_BEEF_CAFE_F00D;
        evt_set_valid = sv; evt_set_idx = 3'(si);
        evt_clr_valid = cv; evt_clr_idx = 3'(ci);
        if (v) begin
            legal = (s == 1 || s == 2 || s == 4 || s == 8) && (a % s == 0)
                    && !(s == 8 && a >= 16 && a < 64);
            if (!legal) begin
                ee = 1'b1; ev = !w;
            end else if (!w) begin
                ev = 1'b1;
                ed = ref_lane(a / 8) >> (8 * (a % 8));
                if (s != 8) ed = ed & ((64'd1 << (8 * s)) - 64'd1);
            end
        end
        if (cv && ci < 5) model_evt = model_evt & ~(1 << ci);
        if (sv && si < 5) model_evt = model_evt | (1 << si);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; evt_set_valid = 1'b0; evt_clr_valid = 1'b0;
        check(tag, rd_valid, acc_err, rd_data, ev, ee, ed);
    endtask

    task automatic rd(string tag, int unsigned a, int unsigned s);
        step(tag, 1, 0, a, s, 0, 0, 0, 0);
    endtask

    task automatic wr(string tag, int unsigned a, int unsigned s);
        step(tag, 1, 1, a, s, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R8 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset outputs", rd_valid, acc_err, rd_data, 1'b0, 1'b0, 64'h0);
        rd("R1 events clear after reset", 'h100, 8);
        step("R8 idle no response", 0, 0, 0, 8, 0, 0, 0, 0);

        rd("R2 header 8B", 'h000, 8);
        rd("R7 header 2B at 2", 'h002, 2);
        rd("R7 header 4B at 4", 'h004, 4);
        rd("R7 header 1B at 2", 'h002, 1);
        rd("R7 header 1B at 4", 'h004, 1);
        for (int a = 'h10; a < 'h40; a += 4) rd("R3 capability entry word", a, 4);
        rd("R3 entry 2B", 'h1A, 2);
        rd("R3 entry 1B", 'h35, 1);

        rd("R4 memdev 8B", 'h200, 8);
        rd("R4 memdev 1B", 'h200, 1);
        rd("R4 memdev 4B upper", 'h204, 4);

        step("R5 set 0", 0, 0, 0, 8, 1, 0, 0, 0);
        step("R5 set 2", 0, 0, 0, 8, 1, 2, 0, 0);
        step("R5 set 4", 0, 0, 0, 8, 1, 4, 0, 0);
        rd("R5 read 0x15", 'h100, 8);
        step("R5 clear 2", 0, 0, 0, 8, 0, 0, 1, 2);
        rd("R5 read after clear", 'h100, 4);
        step("R5 set+clear same idx 1 set wins", 0, 0, 0, 8, 1, 1, 1, 1);
        rd("R5 read set wins", 'h100, 1);
        step("R5 set idx 5 ignored", 0, 0, 0, 8, 1, 5, 0, 0);
        step("R5 clear idx 7 ignored", 0, 0, 0, 8, 0, 0, 1, 7);
        rd("R5 read after out-of-range", 'h100, 8);
        step("R6 read with same-cycle set", 1, 0, 'h100, 8, 1, 3, 0, 0);
        step("R6 read with same-cycle clear", 1, 0, 'h100, 8, 0, 0, 1, 0);
        rd("R6 read settled", 'h100, 8);

        rd("R8 back-to-back a", 'h000, 8);
        rd("R8 back-to-back b", 'h200, 8);
        rd("R8 back-to-back c", 'h018, 4);
        step("R8 idle after burst", 0, 0, 0, 8, 0, 0, 0, 0);

        rd("R9 misaligned 2B", 'h001, 2);
        rd("R9 misaligned 4B", 'h102, 4);
        rd("R9 misaligned 8B", 'h204, 8);
        rd("R9 size 3", 'h000, 3);
        rd("R9 size 0", 'h000, 0);
        rd("R9 size 5", 'h000, 5);
        rd("R9 size 15", 'h000, 15);
        wr("R9 bad write", 'h003, 4);
        rd("R8 good read after error", 'h200, 8);

        rd("R10 8B at 0x10", 'h010, 8);
        rd("R10 8B at 0x38", 'h038, 8);
        rd("R10 8B at 0x40 legal", 'h040, 8);
        rd("R10 8B at 0x08 legal", 'h008, 8);

        wr("R11 write header", 'h000, 8);
        wr("R11 write entry", 'h010, 4);
        wr("R11 write events", 'h100, 8);
        wr("R11 write memdev", 'h200, 8);
        rd("R11 header kept", 'h000, 8);
        rd("R11 entry kept", 'h010, 4);
        rd("R11 events kept", 'h100, 8);
        rd("R11 memdev kept", 'h200, 8);

        rd("R12 mailbox region", 'h180, 8);
        rd("R12 top of window", 'hFF8, 8);
        rd("R12 inside device region", 'h108, 4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule